// File: doc/BRIEF.md
# LDPC Layer Descriptor Regenerator

A layered LDPC decoder reads one column-block address and one barrel-shift amount for every nonzero sub-block of the layer it is about to process. This block is a small descriptor buffer for that decoder. A row of matrix storage that holds the descriptors of a single layer is enough to produce the descriptors of nine consecutive layers. The buffer copies that row in once, through a read port of the memory kind: it gives an index, and the data comes back one cycle later. After that it hands out one descriptor for each accepted fetch.

Each descriptor that is handed out is overwritten in place with its successor for the next layer. If the address sits at position 8 of its group of nine, the address drops by 8 and the shift goes down by one, modulo 40. In every other case the address goes up by one and the shift is kept. After nine full passes the buffer reports that the group is finished, and it serves nothing more until the next load. The decoder addresses layers by their position alone, because every layer has the same row weight.

Top module: `ldpc_layer_info_gen`

## Requirements
- R1: Synchronous reset (`rst` high) empties the buffer. While reset is held and on the cycle after it, `group_done`, `rom_rd_en` and `fetch_valid` are all 0.
- R2: `fetch_req` has no effect while the buffer is empty or still loading: `fetch_valid` stays 0.
- R3: A `load_start` accepted at a clock edge with weight W asserts `rom_rd_en` for exactly W consecutive cycles, starting on the following cycle, with `rom_rd_idx` running 0, 1, …, W−1.
- R4: A `load_start` with a weight of 0 or above 22 is ignored: `rom_rd_en` stays 0 and the buffer stays empty.
- R5: `rom_addr`/`rom_shift` are taken in the cycle after each request. In the first pass the fetches return the loaded pairs in index order, with `fetch_idx` equal to the index and `fetch_last` high only at index W−1. `fetch_layer` is 0 for the first pass and increases by one at each pass boundary.
- R6: If address A mod 9 is not 8, the next pass returns that entry as (A+1, S).
- R7: If A mod 9 is 8, the next pass returns (A−8, S−1).
- R8: If A mod 9 is 8 and S is 0, the new shift is 39.
- R9: The fetch with `fetch_last` high and `fetch_layer` = 8 raises `group_done` on the next cycle. From then on `fetch_req` is ignored.
- R10: A valid `load_start` clears `group_done` and begins a new group at layer 0.
- R11: A cycle without `fetch_req` changes no entry and does not move the pointer: the next fetch returns the index that was due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_start | input | 1 | Begin loading one layer's descriptors |
| load_weight | input | 5 | Number of descriptors to load (1–22) |
| rom_rd_en | output | 1 | Matrix-memory read request |
| rom_rd_idx | output | 5 | Descriptor index being requested |
| rom_addr | input | 11 | Column-block address returned one cycle after request |
| rom_shift | input | 6 | Shift value returned one cycle after request |
| fetch_req | input | 1 | Request the next descriptor |
| fetch_valid | output | 1 | Descriptor outputs are valid and consumed this cycle |
| fetch_addr | output | 11 | Column-block address |
| fetch_shift | output | 6 | Barrel-shift value (0–39) |
| fetch_idx | output | 5 | Position of the entry inside the layer |
| fetch_last | output | 1 | Entry is the final one of the layer |
| fetch_layer | output | 4 | Layer number within the group (0–8) |
| group_done | output | 1 | Nine passes finished; reload required |

## Verification
A corrupt entry or a wrong update rule is visible one pass later, when `fetch_addr` or `fetch_shift` for the same `fetch_idx` differs from the rule applied to the previous pass. A drifting entry pointer or pass counter shows up within one layer as a skipped `fetch_idx`, a `fetch_last` in the wrong place, or `group_done` rising after some number of passes other than nine. Errors in the load path show up during the load, in the sequence of `rom_rd_idx`, or on the first fetch of pass zero.

// File: rtl/ldpc_layer_info_gen.sv
module ldpc_layer_info_gen #(
  parameter int MAX_W     = 22,
  parameter int ADDR_W    = 11,
  parameter int SHIFT_MOD = 40,
  parameter int LAYERS    = 9
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load_start,
  input  logic [$clog2(MAX_W+1)-1:0]     load_weight,
  output logic                           rom_rd_en,
  output logic [$clog2(MAX_W)-1:0]       rom_rd_idx,
  input  logic [ADDR_W-1:0]              rom_addr,
  input  logic [$clog2(SHIFT_MOD)-1:0]   rom_shift,
  input  logic                           fetch_req,
  output logic                           fetch_valid,
  output logic [ADDR_W-1:0]              fetch_addr,
  output logic [$clog2(SHIFT_MOD)-1:0]   fetch_shift,
  output logic [$clog2(MAX_W)-1:0]       fetch_idx,
  output logic                           fetch_last,
  output logic [$clog2(LAYERS)-1:0]      fetch_layer,
  output logic                           group_done
);
  localparam int CNT_W   = $clog2(MAX_W + 1);
  localparam int IDX_W   = $clog2(MAX_W);
  localparam int SHIFT_W = $clog2(SHIFT_MOD);
  localparam int LYR_W   = $clog2(LAYERS);

  typedef enum logic [1:0] {ST_EMPTY, ST_LOAD, ST_RUN, ST_DONE} state_t;

  state_t               state;
  logic [ADDR_W-1:0]    ent_a [MAX_W];
  logic [SHIFT_W-1:0]   ent_s [MAX_W];
  logic [CNT_W-1:0]     weight;
  logic [CNT_W-1:0]     rd_cnt;
  logic                 wr_pend;
  logic [IDX_W-1:0]     wr_idx;
  logic [IDX_W-1:0]     ptr;
  logic [LYR_W-1:0]     layer;

  logic                 load_ok;
  logic [ADDR_W-1:0]    cur_a, nxt_a;
  logic [SHIFT_W-1:0]   cur_s, nxt_s;
  logic                 wrap;

  assign load_ok = load_start && (state != ST_LOAD) &&
                   (load_weight != '0) && (load_weight <= CNT_W'(MAX_W));

  assign rom_rd_en  = (state == ST_LOAD) && (rd_cnt < weight);
  assign rom_rd_idx = IDX_W'(rd_cnt);

  assign cur_a = ent_a[ptr];
  assign cur_s = ent_s[ptr];
  assign wrap  = (cur_a % ADDR_W'(LAYERS)) == ADDR_W'(LAYERS - 1);
  assign nxt_a = wrap ? cur_a - ADDR_W'(LAYERS - 1) : cur_a + ADDR_W'(1);
  assign nxt_s = !wrap ? cur_s :
                 (cur_s == '0) ? SHIFT_W'(SHIFT_MOD - 1) : cur_s - SHIFT_W'(1);

  assign fetch_valid = fetch_req && (state == ST_RUN);
  assign fetch_addr  = cur_a;
  assign fetch_shift = cur_s;
  assign fetch_idx   = ptr;
  assign fetch_last  = (CNT_W'(ptr) + CNT_W'(1)) == weight;
  assign fetch_layer = layer;
  assign group_done  = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_EMPTY;
      weight  <= '0;
      rd_cnt  <= '0;
      wr_pend <= 1'b0;
      wr_idx  <= '0;
      ptr     <= '0;
      layer   <= '0;
      for (int i = 0; i < MAX_W; i++) begin
        ent_a[i] <= '0;
        ent_s[i] <= '0;
      end
    end else begin
      wr_pend <= rom_rd_en;
      wr_idx  <= rom_rd_idx;
      if (load_ok) begin
        state   <= ST_LOAD;
        weight  <= load_weight;
        rd_cnt  <= '0;
        wr_pend <= 1'b0;
        ptr     <= '0;
        layer   <= '0;
      end else begin
        case (state)
          ST_LOAD: begin
            if (rom_rd_en) rd_cnt <= rd_cnt + CNT_W'(1);
            if (wr_pend) begin
              ent_a[wr_idx] <= rom_addr;
              ent_s[wr_idx] <= rom_shift;
              if ((CNT_W'(wr_idx) + CNT_W'(1)) == weight) state <= ST_RUN;
            end
          end
          ST_RUN: begin
            if (fetch_valid) begin
              ent_a[ptr] <= nxt_a;
              ent_s[ptr] <= nxt_s;
              if (fetch_last) begin
                ptr <= '0;
                if (layer == LYR_W'(LAYERS - 1)) state <= ST_DONE;
                else layer <= layer + LYR_W'(1);
              end else begin
                ptr <= ptr + IDX_W'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module ldpc_layer_info_gen_chk #(
  parameter int MAX_W     = 22,
  parameter int SHIFT_MOD = 40,
  parameter int LAYERS    = 9
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         load_start,
  input logic                         rom_rd_en,
  input logic [$clog2(MAX_W)-1:0]     rom_rd_idx,
  input logic                         fetch_valid,
  input logic [$clog2(SHIFT_MOD)-1:0] fetch_shift,
  input logic [$clog2(MAX_W)-1:0]     fetch_idx,
  input logic                         fetch_last,
  input logic [$clog2(LAYERS)-1:0]    fetch_layer,
  input logic                         group_done
);
  localparam int IDX_W   = $clog2(MAX_W);
  localparam int SHIFT_W = $clog2(SHIFT_MOD);
  localparam int LYR_W   = $clog2(LAYERS);

  // R2
  load_blocks_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    rom_rd_en |-> !fetch_valid);

  // R3
  rd_idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rom_rd_en && rom_rd_idx != '0) |-> ($past(rom_rd_en) && rom_rd_idx == $past(rom_rd_idx) + IDX_W'(1)));

  // R5
  fetch_idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_last && !load_start) |=> (!fetch_valid || fetch_idx == $past(fetch_idx) + IDX_W'(1)));

  // R5
  layer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_last && !load_start) |=> $stable(fetch_layer));

  // R8
  shift_range_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> (fetch_shift < SHIFT_W'(SHIFT_MOD)));

  // R9
  group_end_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_last && fetch_layer == LYR_W'(LAYERS - 1) && !load_start) |=> group_done);

  // R9
  done_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    group_done |-> !fetch_valid);
endmodule

bind ldpc_layer_info_gen ldpc_layer_info_gen_chk #(
  .MAX_W(MAX_W), .SHIFT_MOD(SHIFT_MOD), .LAYERS(LAYERS)
) u_chk (.*);

// File: tb/ldpc_layer_info_gen_bench.sv
module ldpc_layer_info_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {A, S, A_next, S_next}
  localparam logic [33:0] VEC [NVEC] = '{
    {11'd8,    6'd0,  11'd0,    6'd39},
    {11'd17,   6'd5,  11'd9,    6'd4},
    {11'd0,    6'd3,  11'd1,    6'd3},
    {11'd1619, 6'd20, 11'd1611, 6'd19},
    {11'd4,    6'd39, 11'd5,    6'd39},
    {11'd26,   6'd1,  11'd18,   6'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_start = 1'b0;
  logic [4:0]  load_weight = '0;
  logic        rom_rd_en;
  logic [4:0]  rom_rd_idx;
  logic [10:0] rom_addr = '0;
  logic [5:0]  rom_shift = '0;
  logic        fetch_req = 1'b0;
  logic        fetch_valid;
  logic [10:0] fetch_addr;
  logic [5:0]  fetch_shift;
  logic [4:0]  fetch_idx;
  logic        fetch_last;
  logic [3:0]  fetch_layer;
  logic        group_done;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [10:0] rom_a_t [22];
  logic [5:0]  rom_s_t [22];
  logic [10:0] exp_a [22];
  logic [5:0]  exp_s [22];

  ldpc_layer_info_gen u_ldpc_layer_info_gen (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : rom_model
    bit pend = 1'b0;
    logic [4:0] pidx = '0;
    forever begin
      @(negedge clk);
      rom_addr  = pend ? rom_a_t[pidx] : 11'd0;
      rom_shift = pend ? rom_s_t[pidx] : 6'd0;
      pend = rom_rd_en;
      pidx = rom_rd_idx;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [16:0] step(input logic [10:0] a, input logic [5:0] s);
    if (a % 9 == 8) return {a - 11'd8, (s == 6'd0) ? 6'd39 : s - 6'd1};
    return {a + 11'd1, s};
  endfunction

  task automatic do_load(input int w);
    load_start = 1'b1;
    load_weight = 5'(w);
    @(negedge clk);
    load_start = 1'b0;
    fetch_req = 1'b1;
    for (int i = 0; i < w; i++) begin
      #1;
      check("R3 rd_en", rom_rd_en, 1);
      check("R3 rd_idx", rom_rd_idx, i);
      check("R2 fetch during load", fetch_valid, 0);
      @(negedge clk);
    end
    #1;
    check("R3 rd_en end", rom_rd_en, 0);
    fetch_req = 1'b0;
    @(negedge clk);
    for (int i = 0; i < w; i++) begin
      exp_a[i] = rom_a_t[i];
      exp_s[i] = rom_s_t[i];
    end
  endtask

  task automatic fetch_one(input string req, input int idx, input int w, input int lyr);
    logic [16:0] n;
    fetch_req = 1'b1;
    #1;
    check({req, " valid"}, fetch_valid, 1);
    check({req, " addr"}, fetch_addr, exp_a[idx]);
    check({req, " shift"}, fetch_shift, exp_s[idx]);
    check("R5 idx", fetch_idx, idx);
    check("R5 last", fetch_last, (idx == w - 1) ? 1 : 0);
    check("R5 layer", fetch_layer, lyr);
    n = step(exp_a[idx], exp_s[idx]);
    exp_a[idx] = n[16:6];
    exp_s[idx] = n[5:0];
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 22; i++) begin
      rom_a_t[i] = '0;
      rom_s_t[i] = '0;
    end
    repeat (3) @(negedge clk);
    fetch_req = 1'b1;
    #1;
    check("R1 group_done", group_done, 0);
    check("R1 rd_en", rom_rd_en, 0);
    check("R1 fetch_valid", fetch_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R2 empty fetch", fetch_valid, 0);
    check("R1 group_done after", group_done, 0);
    fetch_req = 1'b0;

    // R4: out-of-range weights
    foreach (VEC[k]) begin
      rom_a_t[k] = VEC[k][33:23];
      rom_s_t[k] = VEC[k][22:17];
    end
    for (int t = 0; t < 2; t++) begin
      load_start = 1'b1;
      load_weight = (t == 0) ? 5'd0 : 5'd23;
      @(negedge clk);
      load_start = 1'b0;
      fetch_req = 1'b1;
      for (int c = 0; c < 3; c++) begin
        #1;
        check("R4 rd_en", rom_rd_en, 0);
        check("R4 fetch stays empty", fetch_valid, 0);
        @(negedge clk);
      end
      fetch_req = 1'b0;
    end

    // table walk: pass 0 returns loaded pairs, pass 1 returns table successors
    do_load(NVEC);
    for (int k = 0; k < NVEC; k++) fetch_one("R5", k, NVEC, 0);
    for (int k = 0; k < NVEC; k++) begin
      string tag;
      if (VEC[k][33:23] % 9 != 8) tag = "R6";
      else if (VEC[k][22:17] == 6'd0) tag = "R8";
      else tag = "R7";
      check({tag, " table addr"}, exp_a[k], VEC[k][16:6]);
      check({tag, " table shift"}, exp_s[k], VEC[k][5:0]);
      if (k == 3) begin
        // R11: stall for two cycles
        #1;
        check("R11 idle valid", fetch_valid, 0);
        @(negedge clk);
        @(negedge clk);
      end
      fetch_one(tag, k, NVEC, 1);
    end
    for (int l = 2; l < 9; l++)
      for (int k = 0; k < NVEC; k++) fetch_one("R6/R7", k, NVEC, l);
    #1;
    check("R9 group_done", group_done, 1);
    fetch_req = 1'b1;
    #1;
    check("R9 fetch ignored", fetch_valid, 0);
    @(negedge clk);
    fetch_req = 1'b0;

    // R10: reload full-width group
    for (int i = 0; i < 22; i++) begin
      rom_a_t[i] = 11'(i * 37 + 8);
      rom_s_t[i] = 6'(i);
    end
    load_start = 1'b1;
    load_weight = 5'd22;
    #1;
    check("R10 done before load edge", group_done, 1);
    @(negedge clk);
    #1;
    check("R10 done cleared", group_done, 0);
    load_start = 1'b0;
    for (int i = 0; i < 22; i++) begin
      check("R3 rd_idx full", rom_rd_idx, i);
      @(negedge clk);
      #1;
    end
    check("R3 rd_en end full", rom_rd_en, 0);
    @(negedge clk);
    for (int i = 0; i < 22; i++) begin
      exp_a[i] = rom_a_t[i];
      exp_s[i] = rom_s_t[i];
    end
    for (int l = 0; l < 9; l++)
      for (int k = 0; k < 22; k++) fetch_one("R10", k, 22, l);
    #1;
    check("R9 group_done full", group_done, 1);

    // R1: reset mid-run empties the buffer
    rom_a_t[0] = 11'd8;
    rom_s_t[0] = 6'd0;
    do_load(1);
    fetch_one("R8", 0, 1, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    fetch_req = 1'b1;
    #1;
    check("R1 reset clears run", fetch_valid, 0);
    check("R1 reset done", group_done, 0);
    fetch_req = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule